// File: doc/BRIEF.md
# Hybrid Johnson-binary event counter

This block counts clock cycles in which its enable is high, at the full rate of a fast clock, without a long carry chain on the fastest path. The low-order part of the count is kept in a twisted-ring (Johnson) shift register. Each step moves one bit and inverts it, so no carry has to ripple. The ring has `2*RING_W` states and acts as a prescaler for an ordinary `HI_W`-bit binary counter. That counter advances only on the cycle in which the ring returns to all zeros.

A capture strobe copies the raw ring pattern and the binary value in the same clock edge, so the two parts always belong to the same instant. The held pair is then decoded after the register: the ring pattern becomes a value from 0 to `2*RING_W-1`, which is added to `high * 2*RING_W`. Decoding and combining therefore run off the counting path and only change when a new capture is taken. A typical use is a coarse time stamp, with the enable tied high and the strobe pulsed by a synchronised event.

Top module: `hjc_counter`

## Requirements
- R1: After a synchronous reset the captured count output reads 0, and a capture taken before any enabled cycle also reads 0.
- R2: In a cycle with `en` low, neither the ring nor the binary section changes, so a later capture reports the same value as before the idle cycles.
- R3: The binary section increments by exactly one on the edge at which the ring moves from its last state (only the top bit set) back to all zeros, and at no other edge.
- R4: The captured output equals `high*(2*RING_W) + low`. Here `low` is the position of the ring pattern in the sequence 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000 (shown for RING_W=4, bit 0 on the right). The result equals the number of enabled edges since reset, modulo `2^HI_W * 2*RING_W`.
- R5: A capture samples the state present before the capture edge. An increment on that same edge is not included, and the output holds its value on every edge with `cap` low.
- R6: After `2^HI_W * 2*RING_W` enabled cycles from reset the count wraps to 0; one cycle earlier it reads the maximum `2^HI_W * 2*RING_W - 1`.
- R7: The ring only ever holds a legal Johnson pattern (one contiguous run of ones touching bit 0 or the top bit, or all zeros). An illegal pattern is forced to all zeros on the next edge, and single enabled steps visit every legal pattern in order across a wrap.
- R8: Reset takes priority over `en` and `cap` asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; one ring step per edge while high |
| cap | input | 1 | Capture strobe; stores the current ring and binary state |
| count_o | output | HI_W+$clog2(2*RING_W) | Captured count, decoded and combined |

## Verification
The bench drives runs of enabled cycles that stop one short of a ring wrap, exactly on it, and far across many wraps. A design that advanced the binary section on the wrong ring state would report counts that jump or lag by `2*RING_W` near those points. Single-step captures walk through every ring pattern in turn, so a wrong decode of the patterns with bit 0 clear, or a repair path that fires on legal patterns, shows up as a wrong low part. Captures taken on the same edge as an increment, reset asserted together with enable and capture, and a full roll-over of the whole count expose off-by-one capture timing, lost reset priority and wrong wrap width.

// File: rtl/hjc_pkg.sv
package hjc_pkg;

    // True when the set bits of v form a single run that starts at bit 0
    // (all zeros included). Bits at or above w are ignored.
    function automatic logic low_run(input logic [31:0] v, input int unsigned w);
        logic [31:0] mask;
        logic [31:0] vm;
        mask = (w >= 32) ? '1 : ((32'd1 << w) - 32'd1);
        vm   = v & mask;
        return ((vm & (vm + 32'd1)) & mask) == '0;
    endfunction

    // Legal twisted-ring pattern: a run of ones from the bottom, or a run
    // of ones from the top (its complement is a run from the bottom).
    function automatic logic ring_legal(input logic [31:0] v, input int unsigned w);
        return low_run(v, w) || low_run(~v, w);
    endfunction

endpackage

// File: rtl/hjc_ring.sv
module hjc_ring #(
    parameter int unsigned RING_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [RING_W-1:0] ring_o,
    output logic              wrap_o
);
    import hjc_pkg::*;

    localparam logic [RING_W-1:0] LAST_STATE = RING_W'(1) << (RING_W - 1);

    typedef struct packed {
        logic [RING_W-1:0] ring;
    } ring_st_t;

    ring_st_t st_d, st_q;
    logic     legal;
    logic     wrap;

    always_comb begin
        st_d  = st_q;
        wrap  = 1'b0;
        legal = ring_legal(32'(st_q.ring), RING_W);
        if (!legal) begin
            st_d.ring = '0;
        end else if (en) begin
            st_d.ring = {st_q.ring[RING_W-2:0], ~st_q.ring[RING_W-1]};
            wrap      = (st_q.ring == LAST_STATE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ring_o = st_q.ring;
    assign wrap_o = wrap;

endmodule

// File: rtl/hjc_coarse.sv
module hjc_coarse #(
    parameter int unsigned HI_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_i,
    output logic [HI_W-1:0] hi_o
);
    typedef struct packed {
        logic [HI_W-1:0] hi;
    } coarse_st_t;

    coarse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d.hi = st_q.hi + HI_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_o = st_q.hi;

endmodule

// File: rtl/hjc_decode.sv
module hjc_decode #(
    parameter int unsigned RING_W = 4,
    parameter int unsigned LOW_W  = $clog2(2 * RING_W)
) (
    input  logic [RING_W-1:0] ring_i,
    output logic [LOW_W-1:0]  low_o
);
    localparam logic [LOW_W:0] N_STATES = (LOW_W + 1)'(2 * RING_W);

    logic [LOW_W:0] ones;
    logic [LOW_W:0] back;

    always_comb begin
        ones = '0;
        for (int i = 0; i < int'(RING_W); i++) begin
            ones = ones + (LOW_W + 1)'(ring_i[i]);
        end
        back = N_STATES - ones;
        if (ring_i[0] || (ring_i == '0)) begin
            low_o = LOW_W'(ones);
        end else begin
            low_o = LOW_W'(back);
        end
    end

endmodule

// File: rtl/hjc_counter.sv
module hjc_counter #(
    parameter int unsigned RING_W = 4,
    parameter int unsigned HI_W   = 8
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      en,
    input  logic                                      cap,
    output logic [HI_W+$clog2(2*RING_W)-1:0]          count_o
);
    localparam int unsigned LOW_W = $clog2(2 * RING_W);
    localparam int unsigned CNT_W = HI_W + LOW_W;
    localparam logic [CNT_W-1:0] N_STATES = CNT_W'(2 * RING_W);

    typedef struct packed {
        logic [RING_W-1:0] ring;
        logic [HI_W-1:0]   hi;
    } snap_t;

    logic [RING_W-1:0] ring_w;
    logic              wrap_w;
    logic [HI_W-1:0]   hi_w;
    logic [LOW_W-1:0]  low_w;
    snap_t             snap_d, snap_q;

    hjc_ring #(.RING_W(RING_W)) u_ring (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .ring_o (ring_w),
        .wrap_o (wrap_w)
    );

    hjc_coarse #(.HI_W(HI_W)) u_coarse (
        .clk    (clk),
        .rst    (rst),
        .step_i (wrap_w),
        .hi_o   (hi_w)
    );

    always_comb begin
        snap_d = snap_q;
        if (cap) begin
            snap_d.ring = ring_w;
            snap_d.hi   = hi_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end

    hjc_decode #(.RING_W(RING_W), .LOW_W(LOW_W)) u_decode (
        .ring_i (snap_q.ring),
        .low_o  (low_w)
    );

    assign count_o = CNT_W'(snap_q.hi) * N_STATES + CNT_W'(low_w);

endmodule

// File: rtl/hjc_checker.sv
module hjc_checker #(
    parameter int unsigned RING_W = 4,
    parameter int unsigned HI_W   = 8,
    parameter int unsigned CNT_W  = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              cap,
    input logic [RING_W-1:0] ring,
    input logic [HI_W-1:0]   hi,
    input logic [CNT_W-1:0]  count
);
    localparam logic [RING_W-1:0] TOP_ONLY = RING_W'(1) << (RING_W - 1);

    // Legal when adjacent bits differ in at most one place.
    function automatic logic edges_ok(input logic [RING_W-1:0] r);
        int n;
        n = 0;
        for (int i = 0; i < int'(RING_W) - 1; i++) begin
            if (r[i] != r[i+1]) n++;
        end
        return n <= 1;
    endfunction

    AST_RING_LEGAL: assert property (@(posedge clk) disable iff (rst)
        edges_ok(ring)); // R7

    AST_ILLEGAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !edges_ok(ring) |=> (ring == '0)); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(ring) && $stable(hi))); // R2

    AST_HI_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && ring == TOP_ONLY) |=> (hi == HI_W'($past(hi) + HI_W'(1)) && ring == '0)); // R3

    AST_HI_STILL: assert property (@(posedge clk) disable iff (rst)
        !(en && ring == TOP_ONLY) |=> (hi == $past(hi))); // R3

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(count)); // R5

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (count == '0 && ring == '0 && hi == '0)); // R1 R8

endmodule

bind hjc_counter hjc_checker #(
    .RING_W (RING_W),
    .HI_W   (HI_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .cap   (cap),
    .ring  (ring_w),
    .hi    (hi_w),
    .count (count_o)
);

// File: tb/tb_hjc_counter.sv
module tb_hjc_counter;
    localparam int CLK_PERIOD = 10;
    localparam int RING_W = 4;
    localparam int HI_W   = 8;
    localparam int CNT_W  = HI_W + $clog2(2 * RING_W);
    localparam int FULL   = (1 << HI_W) * 2 * RING_W;

    localparam int TAB_N = 9;
    localparam int STEPS [TAB_N] = '{0, 1, 6, 1, 4, 15, 16, 100, 2000};
    localparam int EXPV  [TAB_N] = '{0, 1, 7, 8, 12, 27, 43, 143, 95};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic cap = 1'b0;
    logic [CNT_W-1:0] count_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    hjc_counter #(.RING_W(RING_W), .HI_W(HI_W)) dut (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .cap     (cap),
        .count_o (count_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 200000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not end, got cycle %0d expected below 200000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic step(input logic e, input logic c);
        en  = e;
        cap = c;
        @(negedge clk);
        en  = 1'b0;
        cap = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0);
    endtask

    task automatic check(input string req, input int exp);
        n_chk++;
        if (int'(count_o) != exp) begin
            n_fail++;
            $display("FAIL %s: count got %0d expected %0d", req, count_o, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset output", 0);
        step(1'b0, 1'b1);
        check("R1 capture before counting", 0);

        // Table: enabled runs, then a capture cycle with en low (R4 R3)
        for (int v = 0; v < TAB_N; v++) begin
            run(STEPS[v]);
            step(1'b0, 1'b1);
            check($sformatf("R4 table entry %0d", v), EXPV[v]);
        end

        // R5: capture on the same edge as an increment excludes it
        step(1'b1, 1'b1);
        check("R5 capture with increment", 95);
        step(1'b0, 1'b1);
        check("R5 increment seen next capture", 96);

        // R5: output holds while cap is low
        run(5);
        check("R5 hold without capture", 96);
        step(1'b0, 1'b1);
        check("R5 capture after hold", 101);

        // R2: idle cycles change nothing
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        check("R2 idle cycles", 101);

        // R7: single steps through every ring pattern across a wrap
        for (int k = 1; k <= 10; k++) begin
            step(1'b1, 1'b0);
            step(1'b0, 1'b1);
            check($sformatf("R7 single step %0d", k), 101 + k);
        end

        // R8: reset beats en and cap in the same cycle
        rst = 1'b1;
        step(1'b1, 1'b1);
        rst = 1'b0;
        check("R8 reset priority output", 0);
        step(1'b0, 1'b1);
        check("R8 state cleared by reset", 0);

        // R6: full roll-over
        run(FULL - 1);
        step(1'b0, 1'b1);
        check("R6 maximum count", FULL - 1);
        run(1);
        step(1'b0, 1'b1);
        check("R6 wrap to zero", 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule